// File: doc/BRIEF.md
# Countdown Watchdog with Reset Pulse

This block is an 8-bit countdown watchdog for a system-management subsystem. Firmware arms it by writing a nonzero timeout to the value register. Each pulse on the selected timebase tick lowers the count by one. When the count runs out, the block sets a sticky watchdog flag. If the reset enable is on, it also drives a reset pulse of fixed length. A count of zero means the watchdog is stopped.

The watchdog shares a status register with other flags. Reading that register has a side effect: it forces the count and the value register to zero, which stops the watchdog. Firmware that polls the status register must therefore kick the watchdog again afterwards. The timebase select picks one of several tick inputs. Selection 2 is the 1 Hz tick, and the other selections take prescaled ticks that are generated outside this block.

The register port is a plain single-cycle port. It has a 2-bit address, separate read and write strobes, and combinational read data. The control register sits at address 0, the value register at address 1 and the status register at address 2. Address 3 reads as zero.

Top module: `wdt_top`

## Requirements
- R1: After reset, wdt_rst_o is low, the flag is clear, the value register (address 1) reads 0 and the control register (address 0) reads 0x02, which means reset enable off and timebase selection 2.
- R2: A write to address 1 with a nonzero value loads the counter and the value register and restarts the countdown. Values below 2 are raised to 2. Writing 0 stops the watchdog.
- R3: A running count decrements by one on each clock in which the tick input chosen by control bits [1:0] is high. Ticks on the other tick inputs have no effect.
- R4: When a tick takes the count from 1 to 0, the flag (status bit 6, address 2) is set and the counter stays stopped at 0.
- R5: If control bit 7 is set at timeout, wdt_rst_o is high for RST_CYC clocks, starting in the cycle after the timeout edge. If bit 7 is clear, wdt_rst_o stays low.
- R6: A read of address 2 with no write in the same cycle forces the count and the value register to 0, which stops the watchdog. A later write to address 1 restarts it.
- R7: A read of address 1 returns the loaded value, not the live count.
- R8: Writing address 2 with bit 6 at 0 clears the flag, and writing it with bit 6 at 1 leaves the flag unchanged. A timeout in the same cycle sets the flag regardless of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 4 | Timebase tick pulses, one per selection; index 2 is the 1 Hz tick |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| wdt_rst_o | output | 1 | Reset pulse on timeout |
| wdt_flag_o | output | 1 | Sticky timeout flag |

## Verification
Some properties are checked on every cycle:
- a status read leaves the counter at zero on the next cycle;
- a kick loads exactly the written value;
- a stopped counter stays stopped unless it is kicked;
- the flag rises only on a tick and with the counter at zero;
- a rising reset pulse always comes with the flag set.

Other behaviour needs the bench's scenarios to show it:
- the full countdown length for a given timeout;
- the exact width of the reset pulse;
- the clamping of small timeouts;
- that ticks on the other selections are ignored;
- the flag-clear rules.

The bench checks these against a reference model, both in directed sequences and under random register traffic.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_VAL  = 2'd1,
    A_STAT = 2'd2,
    A_NONE = 2'd3
  } wdt_addr_e;

  localparam int EN_BIT   = 7;
  localparam int FLAG_BIT = 6;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs #(
  parameter int CNT_W   = 8,
  parameter int SEL_W   = 2,
  parameter int SEL_RST = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             stat_we_i,
  input  logic             en_d_i,
  input  logic             flag_d_i,
  input  logic [SEL_W-1:0] sel_d_i,
  input  logic             timeout_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             en_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             flag_o,
  output logic [7:0]       rdata_o
);
  import wdt_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      sel_o <= SEL_W'(SEL_RST);
    end else if (ctrl_we_i) begin
      en_o  <= en_d_i;
      sel_o <= sel_d_i;
    end
  end

  // timeout has priority over a clearing write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    flag_o <= 1'b0;
    else if (timeout_i)             flag_o <= 1'b1;
    else if (stat_we_i && !flag_d_i) flag_o <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[EN_BIT]      = en_o;
        rdata_o[SEL_W-1:0]   = sel_o;
      end
      A_VAL:  rdata_o[CNT_W-1:0] = load_i;
      A_STAT: rdata_o[FLAG_BIT]  = flag_o;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W    = 8,
  parameter int MIN_LOAD = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ld_we_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] load_o,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_LOAD);

  logic [CNT_W-1:0] ld_eff;

  always_comb begin
    if (ld_val_i == '0)        ld_eff = '0;
    else if (ld_val_i < MIN_V) ld_eff = MIN_V;
    else                       ld_eff = ld_val_i;
  end

  assign timeout_o = tick_i && (cnt_o == CNT_W'(1)) && !ld_we_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      load_o <= '0;
    end else if (ld_we_i) begin
      cnt_o  <= ld_eff;
      load_o <= ld_eff;
    end else if (clr_i) begin
      cnt_o  <= '0;
      load_o <= '0;
    end else if (tick_i && cnt_o != '0) begin
      cnt_o  <= cnt_o - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int RST_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int PW = $clog2(RST_CYC + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           left_q <= '0;
    else if (trig_i)       left_q <= PW'(RST_CYC);
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);
endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
  parameter int CNT_W    = 8,
  parameter int SEL_W    = 2,
  parameter int SEL_RST  = 2,
  parameter int MIN_LOAD = 2,
  parameter int RST_CYC  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [(1<<SEL_W)-1:0] tick_i,
  input  logic [1:0]           addr_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  output logic                 wdt_rst_o,
  output logic                 wdt_flag_o
);
  import wdt_pkg::*;

  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_q;
  logic             tick_sel;
  logic             timeout;
  logic             ld_we;
  logic             stat_rd;
  logic             ctrl_we;
  logic             stat_we;

  assign ctrl_we  = wr_i && (addr_i == A_CTRL);
  assign ld_we    = wr_i && (addr_i == A_VAL);
  assign stat_we  = wr_i && (addr_i == A_STAT);
  // side effect of reading the shared status register
  assign stat_rd  = rd_i && !wr_i && (addr_i == A_STAT);
  assign tick_sel = tick_i[sel_q];

  wdt_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W), .SEL_RST(SEL_RST)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_we_i (ctrl_we),
    .stat_we_i (stat_we),
    .en_d_i    (wdata_i[EN_BIT]),
    .flag_d_i  (wdata_i[FLAG_BIT]),
    .sel_d_i   (wdata_i[SEL_W-1:0]),
    .timeout_i (timeout),
    .addr_i    (addr_i),
    .load_i    (load_q),
    .en_o      (en_q),
    .sel_o     (sel_q),
    .flag_o    (wdt_flag_o),
    .rdata_o   (rdata_o)
  );

  wdt_counter #(.CNT_W(CNT_W), .MIN_LOAD(MIN_LOAD)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_sel),
    .ld_we_i   (ld_we),
    .ld_val_i  (wdata_i[CNT_W-1:0]),
    .clr_i     (stat_rd),
    .cnt_o     (cnt_q),
    .load_o    (load_q),
    .timeout_o (timeout)
  );

  wdt_pulse #(.RST_CYC(RST_CYC)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (timeout && en_q),
    .pulse_o (wdt_rst_o)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int CNT_W    = 8,
  parameter int SEL_W    = 2,
  parameter int MIN_LOAD = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [(1<<SEL_W)-1:0] tick_i,
  input logic [1:0]            addr_i,
  input logic                  wr_i,
  input logic                  rd_i,
  input logic [7:0]            wdata_i,
  input logic [CNT_W-1:0]      cnt,
  input logic                  wdt_rst_o,
  input logic                  wdt_flag_o
);
  // R6
  stat_read_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == 2'd2) |=> (cnt == '0));

  // R2
  kick_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd1 && wdata_i[CNT_W-1:0] >= CNT_W'(MIN_LOAD))
      |=> (cnt == $past(wdata_i[CNT_W-1:0])));

  // R4
  stopped_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && !(wr_i && addr_i == 2'd1)) |=> (cnt == '0));

  // R4
  flag_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_flag_o) |-> ($past(|tick_i) && cnt == '0));

  // R5
  rst_with_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> wdt_flag_o);
endmodule

bind wdt_top wdt_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W), .MIN_LOAD(MIN_LOAD)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .wdata_i    (wdata_i),
  .cnt        (cnt_q),
  .wdt_rst_o  (wdt_rst_o),
  .wdt_flag_o (wdt_flag_o)
);

// File: tb/sim_wdt_top.sv
module sim_wdt_top;
  localparam int CLK_PER = 10;
  localparam int RST_CYC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tick = '0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       wrst;
  logic       wflag;

  int total = 0;
  int bad = 0;

  // reference state
  int m_cnt, m_load, m_flag, m_en, m_sel, m_pul;

  always #(CLK_PER/2) clk = ~clk;

  wdt_top #(.RST_CYC(RST_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
    .wdt_rst_o(wrst), .wdt_flag_o(wflag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rdata(input int a);
    case (a)
      0: return (m_en << 7) | m_sel;
      1: return m_load;
      2: return m_flag << 6;
      default: return 0;
    endcase
  endfunction

  function automatic int clamp(input int v);
    if (v == 0) return 0;
    if (v < 2) return 2;
    return v;
  endfunction

  task automatic step(input logic [3:0] tk, input int a, input bit w, input bit r, input int d);
    int n_cnt, n_load, n_flag, n_en, n_sel, n_pul;
    bit tsel, ldwe, clr, to;
    @(negedge clk);
    tick = tk; addr = 2'(a); wr = w; rd = r; wdata = 8'(d);
    #1;
    chk("R7 rdata", int'(rdata), exp_rdata(a));
    tsel = tk[m_sel];
    ldwe = w && a == 1;
    clr  = r && !w && a == 2;
    to   = tsel && m_cnt == 1 && !ldwe && !clr;
    n_cnt = m_cnt; n_load = m_load; n_flag = m_flag;
    n_en = m_en; n_sel = m_sel; n_pul = m_pul;
    if (ldwe) begin n_cnt = clamp(d); n_load = clamp(d); end
    else if (clr) begin n_cnt = 0; n_load = 0; end
    else if (tsel && m_cnt != 0) n_cnt = m_cnt - 1;
    if (to) n_flag = 1;
    else if (w && a == 2 && d[6] == 1'b0) n_flag = 0;
    if (w && a == 0) begin n_en = d[7]; n_sel = d & 3; end
    if (to && m_en == 1) n_pul = RST_CYC;
    else if (m_pul > 0) n_pul = m_pul - 1;
    @(posedge clk);
    #1;
    m_cnt = n_cnt; m_load = n_load; m_flag = n_flag;
    m_en = n_en; m_sel = n_sel; m_pul = n_pul;
    chk("R5 rst_o", int'(wrst), (m_pul > 0) ? 1 : 0);
    chk("R4 flag", int'(wflag), m_flag);
  endtask

  task automatic idle(input logic [3:0] tk);
    step(tk, 3, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    m_cnt = 0; m_load = 0; m_flag = 0; m_en = 0; m_sel = 2; m_pul = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 rst_o", int'(wrst), 0);
    chk("R1 flag", int'(wflag), 0);
    rst_n = 1'b1;
    step('0, 0, 0, 0, 0);
    chk("R1 ctrl", int'(rdata), 8'h02);
    step('0, 1, 0, 0, 0);
    chk("R1 value", int'(rdata), 0);

    // R2 R3 R4 R5: enable reset, load 3, 1 Hz ticks
    step('0, 0, 1, 0, 8'h82);
    step('0, 1, 1, 0, 3);
    idle(4'b1011);                      // R3 other inputs ignored
    chk("R3 no early flag", int'(wflag), 0);
    idle(4'b0100);
    idle(4'b0100);
    chk("R4 not yet", int'(wflag), 0);
    idle(4'b0100);
    chk("R4 flag set", int'(wflag), 1);
    chk("R5 rst high", int'(wrst), 1);
    for (int i = 0; i < RST_CYC - 1; i++) idle(4'b0100);
    chk("R5 rst still high", int'(wrst), 1);
    idle('0);
    chk("R5 rst low", int'(wrst), 0);

    // R8 flag clear rules
    step('0, 2, 1, 0, 8'h40);
    chk("R8 flag kept", int'(wflag), 1);
    step('0, 2, 1, 0, 8'h00);
    chk("R8 flag cleared", int'(wflag), 0);

    // R2 clamp of 1 to 2, R7 readback
    step('0, 1, 1, 0, 1);
    step('0, 1, 0, 1, 0);
    chk("R2 clamp", int'(rdata), 2);
    idle(4'b0100);
    step(4'b0100, 1, 0, 1, 0);
    chk("R7 value not live", int'(rdata), 2);
    chk("R4 flag after 2", int'(wflag), 1);
    step('0, 2, 1, 0, 0);

    // R6 status read stops
    step('0, 1, 1, 0, 5);
    step('0, 2, 0, 1, 0);
    step('0, 1, 0, 1, 0);
    chk("R6 value zeroed", int'(rdata), 0);
    for (int i = 0; i < 8; i++) idle(4'b0100);
    chk("R6 stopped no flag", int'(wflag), 0);

    // R5 disabled reset: flag only
    step('0, 0, 1, 0, 8'h02);
    step('0, 1, 1, 0, 2);
    idle(4'b0100);
    idle(4'b0100);
    chk("R5 flag no rst", int'(wflag), 1);
    chk("R5 no rst", int'(wrst), 0);

    // R2 write 0 stops
    step('0, 2, 1, 0, 0);
    step('0, 1, 1, 0, 4);
    step('0, 1, 1, 0, 0);
    for (int i = 0; i < 6; i++) idle(4'b0100);
    chk("R2 zero stops", int'(wflag), 0);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int op, a, d;
      logic [3:0] tk;
      op = int'($urandom_range(0, 99));
      a  = int'($urandom_range(0, 3));
      d  = int'($urandom_range(0, 255));
      tk = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      if (op < 8)       step(tk, a, 1, 0, d);
      else if (op < 11) step(tk, a, 0, 1, 0);
      else if (op < 12) step(tk, a, 1, 1, d);
      else if (op < 16) step(tk, 1, 1, 0, int'($urandom_range(0, 9)));
      else              step(tk, a, 0, 0, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule